// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of status bytes, one for each finished transmission that the host needs to hear about. The transmitter raises a completion strobe together with the per-frame flags: interrupt requested on success, jabber, underrun and maximum collisions. The block turns each such event into a status byte and queues it.

The host reads the oldest queued byte on a read port. It retires that byte by pulsing a write strobe. A pending output, high whenever anything is queued, feeds the transmit-complete interrupt cause. A jabber or underrun completion latches a halt output that keeps the transmitter stopped. Only a transmit reset or the global reset clears it, and the transmit reset also empties the queue.

Top module: `txstat_stack`

## Requirements
- R1: The status byte is laid out as bit 7 complete, bit 6 interrupt-on-success requested, bit 5 jabber, bit 4 underrun, bit 3 maximum collisions, bit 2 overflow; bits 1 and 0 always read zero.
- R2: The read port presents the oldest entry not yet retired, so entries come out in the order their completions arrived; the queue holds DEPTH entries (default 4).
- R3: A completion carrying none of the four flags queues nothing; a completion with at least one flag queues a byte with bit 7 set and the flag bits copied.
- R4: A pop strobe retires the entry on the read port one cycle later; a pop while the queue is empty changes nothing.
- R5: A completion that arrives while the queue is full, with no pop in the same cycle, is dropped and bit 2 is set in the entry on the read port; with a pop in the same cycle it is queued.
- R6: The pending output is high exactly while at least one entry is queued.
- R7: A completion with jabber or underrun set raises the halt output on the next cycle, whether or not its byte could be queued, and the halt stays high until a reset.
- R8: A transmit reset empties the queue and lowers the halt output on the next edge, overriding any completion or pop in the same cycle.
- R9: The active-low global reset, asynchronous, leaves the queue empty and the halt output low.
- R10: Reading an empty queue returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| done_i | input | 1 | Completion strobe, one cycle per finished frame |
| irq_req_i | input | 1 | Frame asked for an interrupt on success |
| jabber_i | input | 1 | Frame ended in a jabber error |
| underrun_i | input | 1 | Frame ended in an underrun |
| maxcol_i | input | 1 | Frame hit the collision limit |
| pop_i | input | 1 | Host write strobe retiring the oldest entry |
| tx_reset_i | input | 1 | Transmit reset: empties queue, clears halt |
| stat_o | output | 8 | Oldest queued status byte, zero when empty |
| pending_o | output | 1 | At least one entry queued (TX-complete cause) |
| tx_halt_o | output | 1 | Transmitter must stay stopped |

## Verification
Every result is registered once. A completion, pop or transmit reset sampled at one clock edge therefore shows on stat_o, pending_o and tx_halt_o just after that same edge. The global reset acts at once, without waiting for an edge. The bench changes its inputs on the falling edge and lets exactly one rising edge pass. It reads the outputs on the following falling edge, half a period after they settle and half a period before the next edge could change them. The overflow case and the full-with-pop case are run from a queue filled to DEPTH, so the boundary count is the one exercised.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    localparam int STAT_W       = 8;
    localparam int BIT_DONE     = 7;
    localparam int BIT_IRQ      = 6;
    localparam int BIT_JABBER   = 5;
    localparam int BIT_UNDERRUN = 4;
    localparam int BIT_MAXCOL   = 3;
    localparam int BIT_OVF      = 2;

    typedef struct packed {
        logic irq;
        logic jabber;
        logic underrun;
        logic maxcol;
    } tx_event_t;

endpackage

// File: rtl/txstat_fmt.sv
module txstat_fmt
    import txstat_pkg::*;
(
    input  tx_event_t         ev_i,
    output logic [STAT_W-1:0] byte_o,
    output logic              report_o,
    output logic              fatal_o
);

    always_comb begin
        byte_o               = '0;
        byte_o[BIT_DONE]     = 1'b1;
        byte_o[BIT_IRQ]      = ev_i.irq;
        byte_o[BIT_JABBER]   = ev_i.jabber;
        byte_o[BIT_UNDERRUN] = ev_i.underrun;
        byte_o[BIT_MAXCOL]   = ev_i.maxcol;
        report_o = ev_i.irq | ev_i.jabber | ev_i.underrun | ev_i.maxcol;
        fatal_o  = ev_i.jabber | ev_i.underrun;
    end

endmodule

// File: rtl/txstat_store.sv
module txstat_store
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [STAT_W-1:0] push_byte_i,
    input  logic              pop_i,
    output logic [STAT_W-1:0] head_o,
    output logic              nonempty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][STAT_W-1:0] slot;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             count;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    logic             take_pop;
    logic [CNT_W-1:0] cnt_after_pop;
    logic             room;

    always_comb begin
        st_d          = st_q;
        take_pop      = pop_i && (st_q.count != '0);
        cnt_after_pop = st_q.count - CNT_W'(take_pop);
        room          = cnt_after_pop < FULL_CNT;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (take_pop) begin
                st_d.rd = step(st_q.rd);
            end
            st_d.count = cnt_after_pop;
            if (push_i) begin
                if (room) begin
                    st_d.slot[st_q.wr] = push_byte_i;
                    st_d.wr            = step(st_q.wr);
                    st_d.count         = cnt_after_pop + 1'b1;
                end else begin
                    st_d.slot[st_q.rd][BIT_OVF] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nonempty_o = (st_q.count != '0);
    assign head_o     = nonempty_o ? st_q.slot[st_q.rd] : '0;

endmodule

// File: rtl/txstat_guard.sv
module txstat_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_i,
    output logic halt_o
);

    typedef struct packed {
        logic halt;
    } guard_t;

    guard_t gd_d, gd_q;

    always_comb begin
        gd_d = gd_q;
        if (clr_i) begin
            gd_d.halt = 1'b0;
        end else if (set_i) begin
            gd_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gd_q <= '0;
        end else begin
            gd_q <= gd_d;
        end
    end

    assign halt_o = gd_q.halt;

endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              irq_req_i,
    input  logic              jabber_i,
    input  logic              underrun_i,
    input  logic              maxcol_i,
    input  logic              pop_i,
    input  logic              tx_reset_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              pending_o,
    output logic              tx_halt_o
);

    tx_event_t         ev;
    logic [STAT_W-1:0] ev_byte;
    logic              ev_report;
    logic              ev_fatal;

    assign ev = '{irq: irq_req_i, jabber: jabber_i,
                  underrun: underrun_i, maxcol: maxcol_i};

    txstat_fmt u_fmt (
        .ev_i     (ev),
        .byte_o   (ev_byte),
        .report_o (ev_report),
        .fatal_o  (ev_fatal)
    );

    txstat_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tx_reset_i),
        .push_i      (done_i && ev_report),
        .push_byte_i (ev_byte),
        .pop_i       (pop_i),
        .head_o      (stat_o),
        .nonempty_o  (pending_o)
    );

    txstat_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tx_reset_i),
        .set_i  (done_i && ev_fatal),
        .halt_o (tx_halt_o)
    );

endmodule

// File: rtl/txstat_checker.sv
module txstat_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       done_i,
    input logic       irq_req_i,
    input logic       jabber_i,
    input logic       underrun_i,
    input logic       maxcol_i,
    input logic       pop_i,
    input logic       tx_reset_i,
    input logic [7:0] stat_o,
    input logic       pending_o,
    input logic       tx_halt_o
);

    p_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[1:0] == 2'b00);

    p_done_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[7] == pending_o);

    p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |-> stat_o == 8'h00);

    p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !tx_reset_i && (irq_req_i || jabber_i || underrun_i || maxcol_i))
        |=> pending_o);

    p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && pop_i && !done_i) |=> !pending_o);

    p_halt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (jabber_i || underrun_i) && !tx_reset_i) |=> tx_halt_o);

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halt_o && !tx_reset_i) |=> tx_halt_o);

    p_txreset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset_i |=> (!pending_o && !tx_halt_o));

endmodule

bind txstat_stack txstat_checker u_chk (.*);

// File: tb/txstat_stack_test.sv
`timescale 1ns/1ps
module txstat_stack_test;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0, irq_req_i = 1'b0, jabber_i = 1'b0;
    logic       underrun_i = 1'b0, maxcol_i = 1'b0;
    logic       pop_i = 1'b0, tx_reset_i = 1'b0;
    logic [7:0] stat_o;
    logic       pending_o, tx_halt_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    txstat_stack #(.DEPTH(DEPTH)) uut (.*);

    function automatic logic [7:0] mk(input logic irq, jab, und, mc);
        return {1'b1, irq, jab, und, mc, 3'b000};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Start and end on a falling edge; one rising edge samples the inputs.
    task automatic cyc(input logic d, irq, jab, und, mc, pop, txr);
        done_i = d; irq_req_i = irq; jabber_i = jab; underrun_i = und;
        maxcol_i = mc; pop_i = pop; tx_reset_i = txr;
        @(negedge clk);
        done_i = 0; irq_req_i = 0; jabber_i = 0; underrun_i = 0;
        maxcol_i = 0; pop_i = 0; tx_reset_i = 0;
    endtask

    task automatic clear_all();
        cyc(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        chk("R9 pending after reset", pending_o, 0);
        chk("R9 halt after reset", tx_halt_o, 0);
        chk("R10 empty read", stat_o, 8'h00);
    endtask

    task automatic t_format();
        clear_all();
        cyc(1, 1, 0, 0, 1, 0, 0);
        chk("R1 irq+maxcol byte", stat_o, 8'hC8);
        chk("R6 pending set", pending_o, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 0, 1, 1, 0, 0, 0);
        chk("R1 jabber+underrun byte", stat_o, 8'hB0);
        chk("R3 flags copied", stat_o, mk(0, 1, 1, 0));
    endtask

    task automatic t_silent();
        clear_all();
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R3 clean frame not queued", pending_o, 0);
        chk("R3 clean frame read", stat_o, 8'h00);
    endtask

    task automatic t_order();
        clear_all();
        cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 0, 0);
        cyc(1, 1, 0, 0, 1, 0, 0);
        chk("R2 oldest first", stat_o, mk(1, 0, 0, 0));
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R4 pop gives second", stat_o, mk(0, 0, 0, 1));
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R2 third", stat_o, mk(1, 0, 0, 1));
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R6 pending after last pop", pending_o, 0);
    endtask

    task automatic t_pop_empty();
        clear_all();
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 1, 0, 0);
        chk("R4 pop on empty ignored", stat_o, mk(0, 0, 0, 1));
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R4 single pop empties", pending_o, 0);
        chk("R10 read after drain", stat_o, 8'h00);
    endtask

    task automatic t_overflow();
        clear_all();
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 0, i[0], 0, 0);
        cyc(1, 1, 0, 0, 1, 0, 0);
        chk("R5 overflow marks head", stat_o, mk(1, 0, 0, 0) | 8'h04);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R5 next entry unmarked", stat_o, mk(1, 0, 0, 1));
        for (int i = 1; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R5 dropped entry absent", pending_o, 0);
    endtask

    task automatic t_full_swap();
        clear_all();
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 1, 0);
        chk("R5 head after swap", stat_o, mk(1, 0, 0, 0));
        for (int i = 1; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R5 swapped entry kept", stat_o, mk(0, 0, 0, 1));
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R6 empty after swap drain", pending_o, 0);
    endtask

    task automatic t_halt();
        clear_all();
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R7 underrun halts", tx_halt_o, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0, 0, 0);
        chk("R7 halt held", tx_halt_o, 1);
        clear_all();
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0, 0);
        chk("R7 dropped jabber halts", tx_halt_o, 1);
    endtask

    task automatic t_txreset();
        clear_all();
        cyc(1, 0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 1, 1);
        chk("R8 queue emptied", pending_o, 0);
        chk("R8 halt cleared", tx_halt_o, 0);
        chk("R8 read zero", stat_o, 8'h00);
    endtask

    task automatic t_global_reset();
        clear_all();
        cyc(1, 0, 0, 1, 0, 0, 0);
        rst_n = 0;
        #1;
        chk("R9 async clears halt", tx_halt_o, 0);
        chk("R9 async clears queue", pending_o, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 stays clear", {pending_o, tx_halt_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_format();
        t_silent();
        t_order();
        t_pop_empty();
        t_overflow();
        t_full_swap();
        t_halt();
        t_txreset();
        t_global_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule